// File: doc/BRIEF.md
# Tri-Level One-Wire Frame Transmitter

This block is the host side of a one-wire link that carries three signal levels: driven high, driven low, and a middle level that an external resistor divider sets while the pin is released. It takes a write request and turns it into a 40-bit serial frame. The frame holds a sync byte, a device nibble, a fixed tag nibble, a register selector and a 16-bit payload. The block drives the pin through two outputs that feed an external tri-state buffer: a data line and an output enable.

Each bit is sent in three steps. First the data line is set while the buffer is still disabled. Then the buffer is enabled for a programmable number of cycles. Then the pin is released to the middle level for a programmable number of cycles. Because the data line only moves while the buffer is disabled, the pin cannot glitch. In wide mode one request becomes two frames: a low-part frame, then a high-part frame, with a programmable released gap between them. The same gap also follows the last frame before the block takes a new request.

Top module: `trilevel_frame_tx`

## Requirements
- R1: A frame is 40 bits sent most significant bit first. Bits 39..32 are 0xFA, bits 31..28 are the device nibble, bits 27..24 are 0xA, bits 23..16 are the register selector, and bits 15..0 are the payload.
- R2: Each bit takes one setup cycle with the buffer disabled and `pin_data` already at the bit value. It is followed by `drive_cycles` cycles with the buffer enabled, where `pin_data` high sends 1 and low sends 0. It ends with `mid_cycles` cycles with the buffer disabled.
- R3: `pin_data` never changes while the buffer is enabled, and it holds the same value in the cycle just before the enable rises.
- R4: A programmed count of zero for drive, middle or gap behaves as a count of one.
- R5: In narrow mode (`req_wide`=0) a request sends exactly one frame, with selector `reg_addr` and payload `data_word`.
- R6: In wide mode (`req_wide`=1) a request first sends a frame with selector 0x07 and payload {9'b0, `low_bits`}, then a frame with selector 0x06 and payload `data_word`. The pin stays released for `mid_cycles`+`gap_cycles`+1 cycles between the last enable of the first frame and the first enable of the second.
- R7: `busy` is high from the cycle after a request is accepted. It stays high for frames×(40×(1+drive+mid)+gap) cycles, which includes a trailing gap after the last frame.
- R8: A `req_valid` raised while `busy` is high is ignored and changes neither the frames sent nor the busy time.
- R9: With `oe_active_high`=1, a high `pin_oe` enables the buffer. With `oe_active_high`=0, a low `pin_oe` enables it.
- R10: During reset and whenever `busy` is low, the buffer is disabled and `pin_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_wide | input | 1 | 1 selects the two-frame wide mode |
| dev_addr | input | 4 | Device nibble placed in the frame |
| reg_addr | input | 8 | Register selector used in narrow mode |
| data_word | input | 16 | Payload; high part in wide mode |
| low_bits | input | 7 | Low part of the wide-mode value |
| drive_cycles | input | CNT_W | Driven phase length in cycles |
| mid_cycles | input | CNT_W | Released phase length in cycles |
| gap_cycles | input | CNT_W | Released gap after each frame |
| oe_active_high | input | 1 | Enable polarity of `pin_oe` |
| busy | output | 1 | Transfer in progress |
| pin_data | output | 1 | Data line to the buffer |
| pin_oe | output | 1 | Output enable to the buffer |

## Verification
A wrong phase state or a wrong timer value shows up at once as a driven or released run of the wrong length on `pin_oe`. A shifter or bit-index error appears as a wrong bit in the decoded frame, and is seen at the enable edge of that same bit. A lost pending-frame flag is seen at the end of the first frame's gap: either the second frame never starts, or `busy` falls too early. A data line that moves during the enabled phase is caught on the cycle it moves.

// File: rtl/trilevel_pkg.sv
package trilevel_pkg;
    localparam int          FRAME_BITS  = 40;
    localparam logic [7:0]  SYNC_BYTE   = 8'hFA;
    localparam logic [3:0]  TAG_NIBBLE  = 4'hA;
    localparam logic [7:0]  SEL_WIDE_LO = 8'h07;
    localparam logic [7:0]  SEL_WIDE_HI = 8'h06;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_DRIVE,
        PH_MID,
        PH_GAP
    } phase_t;

    typedef struct packed {
        logic [7:0]  sync;
        logic [3:0]  dev;
        logic [3:0]  tag;
        logic [7:0]  sel;
        logic [15:0] payload;
    } frame_t;

    function automatic frame_t make_frame(input logic [3:0] dev,
                                          input logic [7:0] sel,
                                          input logic [15:0] payload);
        frame_t f;
        f.sync    = SYNC_BYTE;
        f.dev     = dev;
        f.tag     = TAG_NIBBLE;
        f.sel     = sel;
        f.payload = payload;
        return f;
    endfunction
endpackage

// File: rtl/tl_phase_timer.sv
module tl_phase_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= (len == '0) ? '0 : len - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R4
    tmr_count_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/tl_bit_shifter.sv
module tl_bit_shifter #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         msb
);
    logic [W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= load_val;
        end else if (shift) begin
            sh_q <= {sh_q[W-2:0], 1'b0};
        end
    end

    assign msb = sh_q[W-1];
endmodule

// File: rtl/trilevel_frame_tx.sv
module trilevel_frame_tx
    import trilevel_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_wide,
    input  logic [3:0]       dev_addr,
    input  logic [7:0]       reg_addr,
    input  logic [15:0]      data_word,
    input  logic [6:0]       low_bits,
    input  logic [CNT_W-1:0] drive_cycles,
    input  logic [CNT_W-1:0] mid_cycles,
    input  logic [CNT_W-1:0] gap_cycles,
    input  logic             oe_active_high,
    output logic             busy,
    output logic             pin_data,
    output logic             pin_oe
);
    localparam int IDX_W = $clog2(FRAME_BITS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    phase_t           ph_q;
    logic [IDX_W-1:0] idx_q;
    logic             pend_q;
    frame_t           hold_q;

    logic             accept;
    logic             tmr_exp;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_len;
    logic             sh_load;
    logic             sh_shift;
    logic             sh_msb;
    logic             drive_en;
    logic             last_bit;
    frame_t           first_frame;

    assign accept   = req_valid && (ph_q == PH_IDLE);
    assign last_bit = (idx_q == LAST_IDX);

    always_comb begin
        if (req_wide)
            first_frame = make_frame(dev_addr, SEL_WIDE_LO, {9'b0, low_bits});
        else
            first_frame = make_frame(dev_addr, reg_addr, data_word);
    end

    always_comb begin
        tmr_load = 1'b0;
        tmr_len  = drive_cycles;
        unique case (ph_q)
            PH_SETUP: begin
                tmr_load = 1'b1;
                tmr_len  = drive_cycles;
            end
            PH_DRIVE: begin
                tmr_load = tmr_exp;
                tmr_len  = mid_cycles;
            end
            PH_MID: begin
                tmr_load = tmr_exp && last_bit;
                tmr_len  = gap_cycles;
            end
            default: begin
                tmr_load = 1'b0;
                tmr_len  = drive_cycles;
            end
        endcase
    end

    assign sh_load  = accept || (ph_q == PH_GAP && tmr_exp && pend_q);
    assign sh_shift = (ph_q == PH_MID) && tmr_exp && !last_bit;

    tl_phase_timer #(.CNT_W(CNT_W)) timer_i (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .len     (tmr_len),
        .expired (tmr_exp)
    );

    tl_bit_shifter #(.W(FRAME_BITS)) shifter_i (
        .clk      (clk),
        .rst      (rst),
        .load     (sh_load),
        .load_val (accept ? first_frame : hold_q),
        .shift    (sh_shift),
        .msb      (sh_msb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            idx_q  <= '0;
            pend_q <= 1'b0;
            hold_q <= '0;
        end else begin
            unique case (ph_q)
                PH_IDLE: begin
                    if (accept) begin
                        ph_q   <= PH_SETUP;
                        idx_q  <= '0;
                        pend_q <= req_wide;
                        hold_q <= make_frame(dev_addr, SEL_WIDE_HI, data_word);
                    end
                end
                PH_SETUP: ph_q <= PH_DRIVE;
                PH_DRIVE: if (tmr_exp) ph_q <= PH_MID;
                PH_MID: begin
                    if (tmr_exp) begin
                        if (last_bit) begin
                            ph_q <= PH_GAP;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                            ph_q  <= PH_SETUP;
                        end
                    end
                end
                PH_GAP: begin
                    if (tmr_exp) begin
                        if (pend_q) begin
                            pend_q <= 1'b0;
                            idx_q  <= '0;
                            ph_q   <= PH_SETUP;
                        end else begin
                            ph_q <= PH_IDLE;
                        end
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    assign busy     = (ph_q != PH_IDLE);
    assign drive_en = (ph_q == PH_DRIVE);
    assign pin_data = (ph_q == PH_SETUP || ph_q == PH_DRIVE || ph_q == PH_MID) ? sh_msb : 1'b0;
    assign pin_oe   = oe_active_high ? drive_en : ~drive_en;

    // R3
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (drive_en && $past(drive_en)) |-> $stable(pin_data));

    // R3
    setup_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(drive_en) |-> $stable(pin_data));

    // R7
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> busy);

    // R1
    idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        idx_q <= LAST_IDX);

    // R6
    pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_GAP && tmr_exp && pend_q) |=> (ph_q == PH_SETUP && !pend_q));
endmodule

// File: tb/trilevel_frame_tx_tb_top.sv
module trilevel_frame_tx_tb_top;
    localparam int CW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_wide = 1'b0;
    logic [3:0]    dev_addr = '0;
    logic [7:0]    reg_addr = '0;
    logic [15:0]   data_word = '0;
    logic [6:0]    low_bits = '0;
    logic [CW-1:0] drive_cycles = '0;
    logic [CW-1:0] mid_cycles = '0;
    logic [CW-1:0] gap_cycles = '0;
    logic          oe_active_high = 1'b1;
    logic          busy, pin_data, pin_oe;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    trilevel_frame_tx #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_wide(req_wide),
        .dev_addr(dev_addr), .reg_addr(reg_addr), .data_word(data_word),
        .low_bits(low_bits), .drive_cycles(drive_cycles), .mid_cycles(mid_cycles),
        .gap_cycles(gap_cycles), .oe_active_high(oe_active_high),
        .busy(busy), .pin_data(pin_data), .pin_oe(pin_oe)
    );

    // fields: wide, oe_hi, dev[4], sel[8], data[16], low[7], drive[8], mid[8], gap[8]
    localparam int VW = 61;
    localparam logic [VW-1:0] VECS [4] = '{
        {1'b0, 1'b1, 4'h0, 8'h06, 16'h139F, 7'h00, 8'd3, 8'd4, 8'd5},
        {1'b1, 1'b0, 4'h0, 8'h00, 16'h139F, 7'h0A, 8'd2, 8'd3, 8'd7},
        {1'b0, 1'b0, 4'h5, 8'h3C, 16'h8001, 7'h00, 8'd2, 8'd6, 8'd2},
        {1'b1, 1'b1, 4'hF, 8'h00, 16'hFFFF, 7'h7F, 8'd0, 8'd0, 8'd0}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [39:0] exp_frame(input logic [3:0] dev,
                                              input logic [7:0] sel,
                                              input logic [15:0] pl);
        return {8'hFA, dev, 4'hA, sel, pl};
    endfunction

    function automatic int eff(input logic [7:0] x);
        return (x == 0) ? 1 : int'(x);
    endfunction

    task automatic run_case(input logic [VW-1:0] v, input bit inj);
        logic        wide  = v[60];
        logic        oehi  = v[59];
        logic [3:0]  dev   = v[58:55];
        logic [7:0]  sel   = v[54:47];
        logic [15:0] dat   = v[46:31];
        logic [6:0]  lowb  = v[30:24];
        int d = eff(v[23:16]);
        int m = eff(v[15:8]);
        int g = eff(v[7:0]);
        int nfr = wide ? 2 : 1;
        logic [39:0] rx [2];
        logic [39:0] ex [2];
        int nbits = 0;
        int drun = 0, rrun = 0, bc = 0;
        bit prev_en = 0, prev_dat = 0;
        bit hold_err = 0, setup_err = 0, drive_err = 0, rel_err = 0, gap_err = 0;
        bit first_busy;
        rx[0] = '0; rx[1] = '0;
        if (wide) begin
            ex[0] = exp_frame(dev, 8'h07, {9'b0, lowb});
            ex[1] = exp_frame(dev, 8'h06, dat);
        end else begin
            ex[0] = exp_frame(dev, sel, dat);
            ex[1] = '0;
        end
        @(negedge clk);
        oe_active_high = oehi;
        req_wide = wide; dev_addr = dev; reg_addr = sel; data_word = dat; low_bits = lowb;
        drive_cycles = CW'(v[23:16]); mid_cycles = CW'(v[15:8]); gap_cycles = CW'(v[7:0]);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        first_busy = busy;
        check(first_busy, "R7", "busy after accept", first_busy, 1);
        for (int guard = 0; guard < 20000; guard++) begin
            bit en;
            en = oehi ? pin_oe : ~pin_oe;
            if (!busy) begin
                check(!en && !pin_data, "R10", "idle released and low", {en, pin_data}, 0);
                break;
            end
            bc++;
            if (inj && bc == 6) begin
                req_valid = 1'b1; reg_addr = 8'h55; data_word = 16'h1234; req_wide = 1'b1;
            end
            if (inj && bc == 7) req_valid = 1'b0;
            if (en && !prev_en) begin
                int expr;
                if (pin_data != prev_dat) setup_err = 1;
                expr = (nbits == 0) ? 1 : ((nbits % 40 == 0) ? m + g + 1 : m + 1);
                if (nbits % 40 == 0 && nbits != 0) begin
                    if (rrun != expr) gap_err = 1;
                end else if (rrun != expr) rel_err = 1;
                if (nbits < 80) rx[nbits / 40] = {rx[nbits / 40][38:0], pin_data};
                nbits++;
                rrun = 0;
            end
            if (en && prev_en && pin_data != prev_dat) hold_err = 1;
            if (!en && prev_en) begin
                if (drun != d) drive_err = 1;
                drun = 0;
            end
            if (en) drun++; else rrun++;
            prev_en = en; prev_dat = pin_data;
            @(negedge clk);
        end
        check(nbits == 40 * nfr, "R5", "bit count", nbits, 40 * nfr);
        check(rx[0] == ex[0], "R1", "first frame", rx[0], ex[0]);
        if (wide) check(rx[1] == ex[1], "R6", "second frame", rx[1], ex[1]);
        check(!setup_err, "R3", "setup cycle data", setup_err, 0);
        check(!hold_err, "R3", "data stable while driven", hold_err, 0);
        check(!drive_err, "R2", "driven run length", drive_err, 0);
        check(!rel_err, "R2", "released run length", rel_err, 0);
        if (wide) check(!gap_err, "R6", "inter-frame gap", gap_err, 0);
        check(rrun == m + g, "R7", "trailing release", rrun, m + g);
        check(bc == nfr * (40 * (1 + d + m) + g), "R7", "busy cycles", bc,
              nfr * (40 * (1 + d + m) + g));
        if (inj) check(nbits == 40 && rx[0] == ex[0], "R8", "request while busy ignored",
                       rx[0], ex[0]);
        if (v[23:16] == 0) check(d == 1 && !drive_err, "R4", "zero counts act as one", drive_err, 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && pin_oe == 1'b0 && !pin_data, "R10", "state in reset",
              {busy, pin_oe, pin_data}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !pin_data, "R10", "state after reset", {busy, pin_data}, 0);
        for (int i = 0; i < 4; i++) begin
            run_case(VECS[i], 1'b0);
            if (!VECS[i][59]) check(pin_oe == 1'b1, "R9", "active-low idle level", pin_oe, 1);
            else check(pin_oe == 1'b0, "R9", "active-high idle level", pin_oe, 0);
        end
        run_case(VECS[2], 1'b1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule